// File: doc/BRIEF.md
# DS3 Transmit Overhead Override Unit

This block sits in the serial transmit path of a DS3 framer. It replaces selected overhead bits and the payload of outgoing M-frames according to a byte-wide maintenance control register. Each accepted bit comes with a slot tag that gives the subframe number, the block number within that subframe, and whether the bit is the overhead bit that opens the block or a payload bit. The receive side supplies the X-bit value it has derived. The unit drives the result out one clock later.

There are three override commands, each ignored while a stronger one is active. Idle fills the payload with a repeating two-ones-two-zeros sequence, forces the X bits high and clears the three C bits of subframe 3. Yellow forces the X bits low. Force-high sets the X bits to one. The AIS and LOS request bits of the register do not generate patterns here, because a later stage makes them. Inside this unit they only suppress the three commands above. A register write lands at once in a readable holding copy. The copy that steers the bit stream is loaded from it only on the first bit of an M-frame, so one frame never carries a mix of X-bit values.

Top module: `ds3_tx_ovr`

## Requirements
- R1: After reset the control register reads 0x07 and `out_valid` is 0.
- R2: A read at address 0x30 returns, one clock later, the last value written at 0x30. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: An X slot (overhead bit of block 0 in subframe 1 or 2) carries `gen_x` when no override acts on it.
- R4: With bit 7 (yellow) set and no stronger command, every X slot is 0.
- R5: With bit 6 (force-high) set and no stronger command, every X slot is 1.
- R6: With bit 5 (idle) set and no stronger command, X slots are 1, the overhead bits of blocks 2, 4 and 6 in subframe 3 are 0, and all other overhead bits pass unchanged.
- R7: In idle, payload bits follow 1,1,0,0 repeating. The sequence restarts at the first payload bit of each M-frame and advances only on payload bits.
- R8: Bit 4 (AIS) or bit 3 (LOS) cancels idle, yellow and force-high. Idle cancels yellow and force-high. Yellow cancels force-high. Bits 2..0 have no effect on the stream.
- R9: A written value steers the stream only from the next accepted bit flagged `in_sof`. A write on that same bit takes effect one frame later.
- R10: `out_valid` is `in_valid` delayed by one clock. `out_bit` is the processed bit of the previous accepted input, and bits with `in_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_valid | input | 1 | Input bit is present |
| in_bit | input | 1 | Input bit |
| in_sof | input | 1 | First bit of an M-frame |
| in_oh | input | 1 | Bit is an overhead slot |
| in_sf | input | SF_W | Subframe number, 1..7 |
| in_blk | input | BLK_W | Block number in subframe, 0..7 |
| gen_x | input | 1 | X-bit value from the receive side |
| out_valid | output | 1 | Output bit is present |
| out_bit | output | 1 | Processed bit |

## Verification
A register write can fall on the same clock as the first bit of an M-frame. The bench writes one value in the middle of a frame and then writes a different value exactly on the next frame-start bit. It judges that the frame-start bit and that whole frame use the mid-frame value, and that the later write applies only from the following frame. Several frames also carry two or more command bits at once, so the priority resolution and the frame-boundary load act together. Every output bit is compared with a behavioural model. Idle cycles with a stray `in_sof` are mixed into the stream to show that they neither load the register nor move the idle sequence.

// File: rtl/ds3ov_pkg.sv
package ds3ov_pkg;
  localparam int          CFG_W   = 8;
  localparam logic [7:0]  CFG_RST = 8'h07;
  localparam int          B_YEL   = 7;
  localparam int          B_XONE  = 6;
  localparam int          B_IDLE  = 5;
  localparam int          B_AIS   = 4;
  localparam int          B_LOS   = 3;

  typedef struct packed {
    logic idle;
    logic yel;
    logic xone;
  } ovr_t;

  typedef enum logic [1:0] {SL_PAY, SL_X, SL_CIDLE, SL_PASS} slot_e;

  function automatic ovr_t resolve(input logic [CFG_W-1:0] c);
    ovr_t r;
    logic blk;
    blk    = c[B_AIS] | c[B_LOS];
    r.idle = c[B_IDLE] & ~blk;
    r.yel  = c[B_YEL]  & ~blk & ~c[B_IDLE];
    r.xone = c[B_XONE] & ~blk & ~c[B_IDLE] & ~c[B_YEL];
    return r;
  endfunction
endpackage

// File: rtl/ds3ov_cfg.sv
module ds3ov_cfg
  import ds3ov_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CFG_W-1:0]  bus_wdata,
  output logic [CFG_W-1:0]  bus_rdata,
  input  logic              frame_go,
  output logic [CFG_W-1:0]  cfg_now,
  output logic [CFG_W-1:0]  act_q
);
  logic [CFG_W-1:0] shadow_q;
  logic             hit;

  assign hit     = (bus_addr == CFG_ADDR);
  assign cfg_now = frame_go ? shadow_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= CFG_RST;
      act_q     <= CFG_RST;
      bus_rdata <= '0;
    end else begin
      if (bus_we && hit) shadow_q <= bus_wdata;
      if (frame_go)      act_q    <= shadow_q;
      bus_rdata <= hit ? shadow_q : '0;
    end
  end
endmodule

// File: rtl/ds3ov_slot.sv
module ds3ov_slot
  import ds3ov_pkg::*;
#(
  parameter int SF_W    = 3,
  parameter int BLK_W   = 3,
  parameter int X_SF_LO = 1,
  parameter int X_SF_HI = 2,
  parameter int C_SF    = 3
) (
  input  logic             in_oh,
  input  logic [SF_W-1:0]  in_sf,
  input  logic [BLK_W-1:0] in_blk,
  output slot_e            slot
);
  logic x_sf, c_blk;

  assign x_sf  = (in_sf >= SF_W'(X_SF_LO)) && (in_sf <= SF_W'(X_SF_HI));
  assign c_blk = (in_blk != '0) && !in_blk[0];

  always_comb begin
    if (!in_oh)                                 slot = SL_PAY;
    else if (x_sf && in_blk == '0)              slot = SL_X;
    else if (in_sf == SF_W'(C_SF) && c_blk)     slot = SL_CIDLE;
    else                                        slot = SL_PASS;
  end
endmodule

// File: rtl/ds3ov_idle_seq.sv
module ds3ov_idle_seq #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic adv,
  output logic pat
);
  localparam int PH_W = (2 * HALF > 2) ? $clog2(2 * HALF) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(2 * HALF - 1);

  logic [PH_W-1:0] ph_q, ph_use;

  assign ph_use = restart ? '0 : ph_q;
  assign pat    = (ph_use < PH_W'(HALF));

  always_ff @(posedge clk) begin
    if (rst)          ph_q <= '0;
    else if (adv)     ph_q <= (ph_use == LAST) ? '0 : ph_use + 1'b1;
    else if (restart) ph_q <= '0;
  end
endmodule

// File: rtl/ds3ov_mux.sv
module ds3ov_mux
  import ds3ov_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             gen_x,
  input  slot_e            slot,
  input  logic [CFG_W-1:0] cfg_now,
  input  logic             pat,
  output logic             out_valid,
  output logic             out_bit
);
  ovr_t ov;
  logic nb;

  assign ov = resolve(cfg_now);

  always_comb begin
    case (slot)
      SL_X:     nb = (ov.idle | ov.xone) ? 1'b1 : (ov.yel ? 1'b0 : gen_x);
      SL_CIDLE: nb = ov.idle ? 1'b0 : in_bit;
      SL_PAY:   nb = ov.idle ? pat  : in_bit;
      default:  nb = in_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bit <= nb;
    end
  end
endmodule

// File: rtl/ds3_tx_ovr.sv
module ds3_tx_ovr
  import ds3ov_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h30,
  parameter int                SUBFRAMES = 7,
  parameter int                BLOCKS    = 8,
  parameter int                IDLE_HALF = 2,
  localparam int               SF_W      = $clog2(SUBFRAMES + 1),
  localparam int               BLK_W     = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              in_sof,
  input  logic              in_oh,
  input  logic [SF_W-1:0]   in_sf,
  input  logic [BLK_W-1:0]  in_blk,
  input  logic              gen_x,
  output logic              out_valid,
  output logic              out_bit
);
  logic [CFG_W-1:0] cfg_now, act_cfg_q;
  logic             frame_go, pat;
  slot_e            slot;

  assign frame_go = in_valid & in_sof;

  ds3ov_cfg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_go(frame_go),
    .cfg_now(cfg_now), .act_q(act_cfg_q)
  );

  ds3ov_slot #(.SF_W(SF_W), .BLK_W(BLK_W)) u_slot (
    .in_oh(in_oh), .in_sf(in_sf), .in_blk(in_blk), .slot(slot)
  );

  ds3ov_idle_seq #(.HALF(IDLE_HALF)) u_idle (
    .clk(clk), .rst(rst), .restart(frame_go),
    .adv(in_valid & ~in_oh), .pat(pat)
  );

  ds3ov_mux u_mux (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .gen_x(gen_x), .slot(slot), .cfg_now(cfg_now), .pat(pat),
    .out_valid(out_valid), .out_bit(out_bit)
  );
endmodule

// File: rtl/ds3ov_chk.sv
module ds3ov_chk
  import ds3ov_pkg::*;
#(
  parameter int SF_W  = 3,
  parameter int BLK_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_oh,
  input logic [SF_W-1:0]  in_sf,
  input logic [BLK_W-1:0] in_blk,
  input logic             gen_x,
  input logic [CFG_W-1:0] act_q,
  input logic             out_valid,
  input logic             out_bit
);
  ovr_t ovn;
  logic xs, cs, blk;

  assign ovn = resolve(act_q);
  assign blk = act_q[B_AIS] | act_q[B_LOS];
  assign xs  = in_oh && (in_sf == SF_W'(1) || in_sf == SF_W'(2)) && in_blk == '0;
  assign cs  = in_oh && in_sf == SF_W'(3) &&
               (in_blk == BLK_W'(2) || in_blk == BLK_W'(4) || in_blk == BLK_W'(6));

  a_r10_valid_pipe: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_gap: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_hold_cfg: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_sof) |=> $stable(act_q));
  a_r3_xgen: assert property (@(posedge clk) disable iff (rst)
    in_valid && xs |=> (ovn != '0 || out_bit == $past(gen_x)));
  a_r4_yellow_zero: assert property (@(posedge clk) disable iff (rst)
    in_valid && xs |=> (!ovn.yel || !out_bit));
  a_r5_xone_high: assert property (@(posedge clk) disable iff (rst)
    in_valid && xs |=> (!ovn.xone || out_bit));
  a_r6_cbits_low: assert property (@(posedge clk) disable iff (rst)
    in_valid && cs |=> (!ovn.idle || !out_bit));
  a_r8_block_wins: assert property (@(posedge clk) disable iff (rst)
    in_valid && xs |=> (!blk || out_bit == $past(gen_x)));
endmodule

bind ds3_tx_ovr ds3ov_chk #(.SF_W(SF_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
  .in_oh(in_oh), .in_sf(in_sf), .in_blk(in_blk), .gen_x(gen_x),
  .act_q(act_cfg_q), .out_valid(out_valid), .out_bit(out_bit)
);

// File: tb/test_ds3_tx_ovr.sv
module test_ds3_tx_ovr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h30;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       in_valid = 1'b0, in_bit = 1'b0, in_sof = 1'b0, in_oh = 1'b0;
  logic [2:0] in_sf = 3'd1, in_blk = 3'd0;
  logic       gen_x = 1'b0;
  logic       out_valid, out_bit;

  int checks = 0, fails = 0, cyc_n = 0;

  ds3_tx_ovr i_ds3_tx_ovr (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_valid(in_valid),
    .in_bit(in_bit), .in_sof(in_sof), .in_oh(in_oh), .in_sf(in_sf),
    .in_blk(in_blk), .gen_x(gen_x), .out_valid(out_valid), .out_bit(out_bit)
  );

  always #4 clk = ~clk;

  // reference model state
  logic [7:0] m_sh = 8'h07, m_act = 8'h07;
  int         m_ph = 0;
  logic       first_rd = 1'b1;
  bit         q_v[$];
  bit         q_b[$];
  logic [7:0] q_rd[$];
  string      q_tag[$];
  string      q_rtag[$];
  logic [15:0] lf = 16'hACE1;

  task automatic fail_line(string tag, string what, int act, int exp);
    fails++;
    $display("FAIL %s: %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc_n);
  endtask

  task automatic compare();
    if (q_v.size() == 0) return;
    begin
      bit ev, eb; logic [7:0] er; string t, rt;
      ev = q_v.pop_front(); eb = q_b.pop_front(); er = q_rd.pop_front();
      t = q_tag.pop_front(); rt = q_rtag.pop_front();
      checks++;
      if (out_valid !== ev) fail_line("R10", "out_valid", out_valid, ev);
      if (ev) begin
        checks++;
        if (out_bit !== eb) fail_line(t, "out_bit", out_bit, eb);
      end
      checks++;
      if (bus_rdata !== er) fail_line(rt, "bus_rdata", bus_rdata, er);
    end
  endtask

  task automatic cyc(bit v, bit b, bit sof, bit oh, int sf, int blk, bit gx,
                     bit we, logic [7:0] addr, logic [7:0] wd);
    logic [7:0] cfg, erd;
    bit eb, blkd, idle, yel, xone, xslot, cslot, ovr;
    int nset;
    string tag;
    @(negedge clk);
    compare();
    cyc_n++;
    in_valid = v; in_bit = b; in_sof = sof; in_oh = oh;
    in_sf = 3'(sf); in_blk = 3'(blk); gen_x = gx;
    bus_we = we; bus_addr = addr; bus_wdata = wd;
    // model: read sees holding copy before this write
    erd = (addr == 8'h30) ? m_sh : 8'h00;
    q_rtag.push_back(first_rd ? "R1" : "R2");
    first_rd = 1'b0;
    if (v && sof) m_act = m_sh;                       // R9
    cfg = m_act;
    if (we && addr == 8'h30) m_sh = wd;
    blkd = cfg[4] || cfg[3];
    idle = cfg[5] && !blkd;
    yel  = cfg[7] && !blkd && !cfg[5];
    xone = cfg[6] && !blkd && !cfg[5] && !cfg[7];
    nset = int'(cfg[7]) + int'(cfg[6]) + int'(cfg[5]) + int'(cfg[4]) + int'(cfg[3]);
    xslot = oh && (sf == 1 || sf == 2) && blk == 0;
    cslot = oh && sf == 3 && (blk == 2 || blk == 4 || blk == 6);
    eb = b; tag = "R10"; ovr = 1'b0;
    if (v) begin
      if (sof) m_ph = 0;
      if (xslot) begin
        ovr = 1'b1;
        if (idle)      begin eb = 1'b1; tag = "R6"; end
        else if (yel)  begin eb = 1'b0; tag = "R4"; end
        else if (xone) begin eb = 1'b1; tag = "R5"; end
        else           begin eb = gx;   tag = "R3"; end
      end else if (cslot) begin
        ovr = 1'b1;
        if (idle) begin eb = 1'b0; tag = "R6"; end
      end else if (!oh) begin
        ovr = 1'b1;
        if (idle) begin eb = ((m_ph % 4) < 2); tag = "R7"; end
        m_ph++;
      end
      if (ovr && nset > 1) tag = "R8";
      if (ovr && m_act != m_sh) tag = {tag, " with R9 pending"};
    end
    q_v.push_back(v); q_b.push_back(eb); q_rd.push_back(erd); q_tag.push_back(tag);
  endtask

  function automatic void lstep();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fail_line("watchdog", "run did not end", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] vals [9];
    int gcnt;
    vals = '{8'h07, 8'h80, 8'h40, 8'h20, 8'hC0, 8'hA0, 8'h30, 8'h88, 8'h48};
    gcnt = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++; if (out_valid !== 1'b0) fail_line("R1", "out_valid in reset", out_valid, 0);
    checks++; if (bus_rdata !== 8'h00) fail_line("R1", "rdata in reset", bus_rdata, 0);
    rst = 1'b0;
    for (int f = 0; f < 11; f++) begin
      for (int sf = 1; sf <= 7; sf++) begin
        for (int bk = 0; bk < 8; bk++) begin
          for (int k = 0; k < 85; k++) begin
            int pos; bit we; logic [7:0] ad, wd;
            pos = ((sf - 1) * 8 + bk) * 85 + k;
            if (gcnt % 53 == 52) begin
              // gap with stray frame flag: must not load or advance (R9, R10)
              lstep();
              cyc(0, lf[0], 1, 0, 1, 0, lf[3], 0, 8'h30, 8'h00);
            end
            gcnt++;
            we = 1'b0; wd = 8'h00;
            ad = (pos % 97 == 50) ? 8'h31 : 8'h30;   // R2 decode
            if (f <= 7 && pos == 2000) begin we = 1'b1; ad = 8'h30; wd = vals[f + 1]; end
            if (f == 8 && pos == 2000) begin we = 1'b1; ad = 8'h30; wd = 8'h20; end
            if (f == 9 && pos == 0)    begin we = 1'b1; ad = 8'h30; wd = 8'h00; end // R9 same-cycle
            if (f == 2 && pos == 3000) begin we = 1'b1; ad = 8'h31; wd = 8'hFF; end // R2 ignored
            lstep();
            cyc(1, lf[0], pos == 0, k == 0, sf, bk, lf[5], we, ad, wd);
          end
        end
      end
    end
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 8'h30, 8'h00);
    @(negedge clk);
    compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule